// File: doc/BRIEF.md
# Four-ADC Simultaneous Conversion Scheduler

This block drives four external 8-channel, 12-bit converters that present their results on parallel buses. A single start strobe is shared by all four devices, so every conversion samples the same channel on all four at the same moment. When the devices report that they are finished, the block reads all four results together. It then writes four tagged entries into an internal result queue, one for each device. Entries leave the queue over a shared response port.

A small command port picks the acquisition mode and the channel. A single acquisition converts once and then stops. A continuous scan converts repeatedly at a fixed start-to-start spacing, stepping the channel each time, until a stop command arrives. Conversions run in the background. Responses from the other command handlers of the controller are forwarded through the same response port at all times, and they always take precedence over queued conversion results.

Top module: `adc_scan_sched`

## Requirements
- R1: After reset, `adc_start_no` is high, `adc_rd_o` is low, `resp_valid_o` is low and `ovf_avoided_o` is low.
- R2: A conversion drives `adc_start_no` low for exactly 2 cycles on all devices together. Once every bit of `adc_busy_i` is low, `adc_rd_o` is driven high for exactly 2 cycles, and all four buses are sampled in the second of those cycles.
- R3: Each conversion writes four queue entries in device order 0, 1, 2, 3. Each entry appears on `resp_data_o` as bits [16:15] = device index, bits [14:12] = channel and bits [11:0] = sample, with all higher bits zero and `resp_src_o` = 1.
- R4: Command code 1 (single) on `cmd_op_i` with `cmd_valid_i` high, issued while idle, performs exactly one conversion on channel `cmd_ch_i` and then returns to idle.
- R5: Command code 2 (scan) issued while idle starts repeated conversions. The first uses `cmd_ch_i`, each following one uses the next channel, and channel 7 is followed by channel 0.
- R6: Two conversion starts are never closer than CONV_GAP cycles apart. During a scan with enough queue room, consecutive starts are exactly CONV_GAP cycles apart.
- R7: Command code 3 (stop) during a scan lets the conversion already in progress be fully stored and prevents any further start. A stop while idle has no effect.
- R8: Single or scan commands received while a conversion sequence is active are ignored and do not change the channel order.
- R9: If the queue has fewer than four free entries when a start is due, the start waits until room is available and `ovf_avoided_o` is set and stays set until reset. A conversion's four entries are never partly written.
- R10: While `oth_valid_i` is high, the response port carries `oth_data_i` with `resp_src_o` = 0 and no queue entry is removed. Queue entries are presented only when `oth_valid_i` is low.
- R11: Other-handler responses pass through in the same cycle while a conversion is running, with `oth_ready_o` equal to `resp_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 none, 1 single, 2 scan, 3 stop |
| cmd_ch_i | input | 3 | Channel for single, or first channel for scan |
| adc_start_no | output | 1 | Shared conversion start, active low |
| adc_busy_i | input | N_ADC | Per-device busy flags |
| adc_rd_o | output | 1 | Shared read enable |
| adc_ch_o | output | 3 | Channel select presented to the devices |
| adc_data_i | input | N_ADC*DATA_W | Concatenated device result buses, device 0 in the low bits |
| oth_valid_i | input | 1 | Response from another handler is pending |
| oth_data_i | input | RESP_W | Response word from another handler |
| oth_ready_o | output | 1 | Other-handler response accepted |
| resp_valid_o | output | 1 | Merged response valid |
| resp_src_o | output | 1 | 0 other handler, 1 conversion queue |
| resp_data_o | output | RESP_W | Merged response word |
| resp_ready_i | input | 1 | Downstream accepts the response |
| ovf_avoided_o | output | 1 | Sticky: a start was held back for lack of queue room |

## Verification
The bench builds the block with CONV_GAP = 40 and FIFO_DEPTH = 8, keeping all other parameters at their defaults. The short spacing allows several scan periods, the channel wrap from 7 to 0 and exact start spacing to be observed within a few hundred cycles. The shallow queue fills after just two conversions while the response port is stalled, so the deferred start, the sticky flag and the no-partial-write rule can all be reached. A behavioural device model gives each of the four devices a different busy length, which exercises the wait for the slowest device.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_SINGLE  = 2'd1,
    OP_SCAN    = 2'd2,
    OP_STOP    = 2'd3
  } cmd_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_CONV,
    S_WAIT,
    S_READ,
    S_PUSH
  } seq_state_e;
endpackage

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] free_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  assign free_o  = CNT_W'(DEPTH) - cnt_q;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_sched_pkg::*;
#(
  parameter int N_ADC    = 4,
  parameter int N_CH     = 8,
  parameter int DATA_W   = 12,
  parameter int CONV_GAP = 208,
  parameter int FREE_W   = 5,
  localparam int IDX_W   = (N_ADC > 1) ? $clog2(N_ADC) : 1,
  localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int EW      = IDX_W + CH_W + DATA_W,
  localparam int GAP_W   = $clog2(CONV_GAP + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  cmd_op_e                 cmd_op_i,
  input  logic [CH_W-1:0]         cmd_ch_i,
  input  logic [N_ADC-1:0]        adc_busy_i,
  input  logic [N_ADC*DATA_W-1:0] adc_data_i,
  input  logic [FREE_W-1:0]       fifo_free_i,
  output logic                    adc_start_no,
  output logic                    adc_rd_o,
  output logic [CH_W-1:0]         adc_ch_o,
  output logic                    push_o,
  output logic [EW-1:0]           push_data_o,
  output logic                    ovf_o
);
  seq_state_e               state_q;
  logic                     scan_q, stop_q, ph_q, ovf_q;
  logic [CH_W-1:0]          ch_q;
  logic [IDX_W-1:0]         idx_q;
  logic [GAP_W-1:0]         gap_q;
  logic [N_ADC-1:0][DATA_W-1:0] samp_q;
  logic                     room;

  assign room         = fifo_free_i >= FREE_W'(N_ADC);
  assign adc_start_no = (state_q != S_CONV);
  assign adc_rd_o     = (state_q == S_READ);
  assign adc_ch_o     = ch_q;
  assign push_o       = (state_q == S_PUSH);
  assign push_data_o  = {idx_q, ch_q, samp_q[idx_q]};
  assign ovf_o        = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      scan_q  <= 1'b0;
      stop_q  <= 1'b0;
      ph_q    <= 1'b0;
      ovf_q   <= 1'b0;
      ch_q    <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_valid_i && (cmd_op_i == OP_SINGLE || cmd_op_i == OP_SCAN)) begin
            ch_q    <= cmd_ch_i;
            scan_q  <= (cmd_op_i == OP_SCAN);
            stop_q  <= 1'b0;
            state_q <= S_ARM;
          end
        end
        S_ARM: begin
          if (stop_q) begin
            state_q <= S_IDLE;
            scan_q  <= 1'b0;
            stop_q  <= 1'b0;
          end else if (gap_q == '0) begin
            if (room) begin
              state_q <= S_CONV;
              gap_q   <= GAP_W'(CONV_GAP - 1);
              ph_q    <= 1'b0;
            end else begin
              ovf_q <= 1'b1;
            end
          end
        end
        S_CONV: begin
          ph_q <= ~ph_q;
          if (ph_q) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (adc_busy_i == '0) begin
            state_q <= S_READ;
            ph_q    <= 1'b0;
          end
        end
        S_READ: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            idx_q   <= '0;
            state_q <= S_PUSH;
          end
        end
        S_PUSH: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(N_ADC - 1)) begin
            if (scan_q && !stop_q) begin
              ch_q    <= (ch_q == CH_W'(N_CH - 1)) ? '0 : ch_q + 1'b1;
              state_q <= S_ARM;
            end else begin
              state_q <= S_IDLE;
              scan_q  <= 1'b0;
              stop_q  <= 1'b0;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
      if (cmd_valid_i && cmd_op_i == OP_STOP && scan_q && state_q != S_IDLE)
        stop_q <= 1'b1;
    end
  end

  // capture all buses on the second read cycle
  for (genvar g = 0; g < N_ADC; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             samp_q[g] <= '0;
      else if (state_q == S_READ && ph_q)      samp_q[g] <= adc_data_i[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/resp_merge.sv
module resp_merge #(
  parameter int RESP_W = 32,
  parameter int EW     = 17
) (
  input  logic              oth_valid_i,
  input  logic [RESP_W-1:0] oth_data_i,
  output logic              oth_ready_o,
  input  logic              q_empty_i,
  input  logic [EW-1:0]     q_data_i,
  output logic              q_pop_o,
  output logic              resp_valid_o,
  output logic              resp_src_o,
  output logic [RESP_W-1:0] resp_data_o,
  input  logic              resp_ready_i
);
  always_comb begin
    oth_ready_o  = 1'b0;
    q_pop_o      = 1'b0;
    resp_valid_o = 1'b0;
    resp_src_o   = 1'b0;
    resp_data_o  = '0;
    if (oth_valid_i) begin
      resp_valid_o = 1'b1;
      resp_data_o  = oth_data_i;
      oth_ready_o  = resp_ready_i;
    end else if (!q_empty_i) begin
      resp_valid_o = 1'b1;
      resp_src_o   = 1'b1;
      resp_data_o  = RESP_W'(q_data_i);
      q_pop_o      = resp_ready_i;
    end
  end
endmodule

// File: rtl/adc_scan_sched.sv
module adc_scan_sched
  import adc_sched_pkg::*;
#(
  parameter int N_ADC      = 4,
  parameter int N_CH       = 8,
  parameter int DATA_W     = 12,
  parameter int CONV_GAP   = 208,
  parameter int FIFO_DEPTH = 16,
  parameter int RESP_W     = 32,
  localparam int IDX_W     = (N_ADC > 1) ? $clog2(N_ADC) : 1,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int EW        = IDX_W + CH_W + DATA_W,
  localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [CH_W-1:0]         cmd_ch_i,
  output logic                    adc_start_no,
  input  logic [N_ADC-1:0]        adc_busy_i,
  output logic                    adc_rd_o,
  output logic [CH_W-1:0]         adc_ch_o,
  input  logic [N_ADC*DATA_W-1:0] adc_data_i,
  input  logic                    oth_valid_i,
  input  logic [RESP_W-1:0]       oth_data_i,
  output logic                    oth_ready_o,
  output logic                    resp_valid_o,
  output logic                    resp_src_o,
  output logic [RESP_W-1:0]       resp_data_o,
  input  logic                    resp_ready_i,
  output logic                    ovf_avoided_o
);
  logic              push, pop, q_empty;
  logic [EW-1:0]     push_data, q_data;
  logic [FREE_W-1:0] fifo_free;

  adc_conv_seq #(
    .N_ADC(N_ADC), .N_CH(N_CH), .DATA_W(DATA_W),
    .CONV_GAP(CONV_GAP), .FREE_W(FREE_W)
  ) seq_i (
    .clk_i, .rst_ni, .cmd_valid_i,
    .cmd_op_i    (cmd_op_e'(cmd_op_i)),
    .cmd_ch_i, .adc_busy_i, .adc_data_i,
    .fifo_free_i (fifo_free),
    .adc_start_no, .adc_rd_o, .adc_ch_o,
    .push_o      (push),
    .push_data_o (push_data),
    .ovf_o       (ovf_avoided_o)
  );

  adc_res_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (push_data),
    .pop_i   (pop),
    .dout_o  (q_data),
    .empty_o (q_empty),
    .free_o  (fifo_free)
  );

  resp_merge #(.RESP_W(RESP_W), .EW(EW)) merge_i (
    .oth_valid_i, .oth_data_i, .oth_ready_o,
    .q_empty_i (q_empty),
    .q_data_i  (q_data),
    .q_pop_o   (pop),
    .resp_valid_o, .resp_src_o, .resp_data_o, .resp_ready_i
  );
endmodule

// File: rtl/adc_scan_sched_chk.sv
module adc_scan_sched_chk #(
  parameter int N_ADC    = 4,
  parameter int CONV_GAP = 208,
  parameter int FREE_W   = 5,
  localparam int GC_W    = $clog2(CONV_GAP + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_start_no,
  input logic              adc_rd_o,
  input logic              oth_valid_i,
  input logic              resp_valid_o,
  input logic              resp_src_o,
  input logic              ovf_avoided_o,
  input logic [FREE_W-1:0] fifo_free
);
  logic            prev_start_n;
  logic [GC_W-1:0] since_q;
  logic            start_fall;

  assign start_fall = prev_start_n && !adc_start_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_start_n <= 1'b1;
      since_q      <= GC_W'(CONV_GAP);
    end else begin
      prev_start_n <= adc_start_no;
      if (start_fall)                     since_q <= GC_W'(1);
      else if (since_q != GC_W'(CONV_GAP)) since_q <= since_q + 1'b1;
    end
  end

  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_start_no) |=> !adc_start_no); // R2
  AST_START_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_start_no && $past(!adc_start_no)) |=> adc_start_no); // R2
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_rd_o) |=> adc_rd_o); // R2
  AST_RD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rd_o && $past(adc_rd_o)) |=> !adc_rd_o); // R2
  AST_START_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fall |-> (since_q == GC_W'(CONV_GAP))); // R6
  AST_ROOM_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fall |-> (fifo_free >= FREE_W'(N_ADC))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_avoided_o |=> ovf_avoided_o); // R9
  AST_OTHER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oth_valid_i |-> (resp_valid_o && !resp_src_o)); // R10
endmodule

bind adc_scan_sched adc_scan_sched_chk #(
  .N_ADC(N_ADC), .CONV_GAP(CONV_GAP), .FREE_W(FREE_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .adc_start_no(adc_start_no),
  .adc_rd_o(adc_rd_o), .oth_valid_i(oth_valid_i), .resp_valid_o(resp_valid_o),
  .resp_src_o(resp_src_o), .ovf_avoided_o(ovf_avoided_o), .fifo_free(fifo_free)
);

// File: tb/adc_scan_sched_tb_top.sv
module adc_scan_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 40;
  localparam int DEPTH      = 8;
  localparam int NA         = 4;
  localparam int DW         = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [2:0]    cmd_ch = 3'd0;
  logic          start_n, rd, oth_ready, resp_valid, resp_src, ovf;
  logic [2:0]    ach;
  logic [NA-1:0] busy;
  logic [NA*DW-1:0] adata;
  logic          oth_valid = 1'b0;
  logic [31:0]   oth_data = '0;
  logic [31:0]   resp_data;
  logic          resp_ready = 1'b0;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_scan_sched #(.CONV_GAP(GAP), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ch_i(cmd_ch), .adc_start_no(start_n), .adc_busy_i(busy), .adc_rd_o(rd),
    .adc_ch_o(ach), .adc_data_i(adata), .oth_valid_i(oth_valid),
    .oth_data_i(oth_data), .oth_ready_o(oth_ready), .resp_valid_o(resp_valid),
    .resp_src_o(resp_src), .resp_data_o(resp_data), .resp_ready_i(resp_ready),
    .ovf_avoided_o(ovf)
  );

  // device model: per-device busy length, sample encodes device, channel, sequence
  int       bcnt [NA];
  logic [6:0] seq = '0;
  logic     prev_sn = 1'b1;
  always @(posedge clk) begin
    prev_sn <= start_n;
    if (!start_n && prev_sn) seq <= seq + 1'b1;
    for (int i = 0; i < NA; i++) begin
      if (!start_n)         bcnt[i] <= 10 + 3 * i;
      else if (bcnt[i] != 0) bcnt[i] <= bcnt[i] - 1;
    end
  end
  always_comb begin
    for (int i = 0; i < NA; i++) begin
      busy[i] = (bcnt[i] != 0);
      adata[i*DW +: DW] = rd ? {i[1:0], ach, seq} : '0;
    end
  end

  // monitor at the falling edge
  int n_got = 0, n_fall = 0, low_len = 0, last_low = 0, rd_len = 0, last_rd = 0;
  logic [31:0] got [64];
  int fall_t [64];
  logic mon_prev = 1'b1;
  always @(negedge clk) begin
    if (resp_valid && resp_ready && resp_src && n_got < 64) begin
      got[n_got] = resp_data;
      n_got++;
    end
    if (!start_n && mon_prev && n_fall < 64) begin
      fall_t[n_fall] = cyc;
      n_fall++;
    end
    mon_prev = start_n;
    if (!start_n) low_len++;
    else if (low_len != 0) begin last_low = low_len; low_len = 0; end
    if (rd) rd_len++;
    else if (rd_len != 0) begin last_rd = rd_len; rd_len = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [2:0] ch);
    step(1);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch;
    step(1);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic clr();
    @(posedge clk); #1;
    n_got = 0; n_fall = 0;
  endtask

  task automatic wait_falls(input int n);
    for (int k = 0; k < 2000 && n_fall < n; k++) step(1);
  endtask

  // check group g of collected entries against device order, channel and sequence
  task automatic chk_group(input int g, input logic [2:0] ch, input logic [6:0] sq, input string req);
    for (int a = 0; a < NA; a++) begin
      logic [31:0] e;
      logic [31:0] exp;
      e = got[4*g + a];
      exp = {15'd0, a[1:0], ch, a[1:0], ch, sq};
      chk(e == exp, req, int'(e), int'(exp));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(start_n == 1'b1, "R1 start", int'(start_n), 1);
    chk(rd == 1'b0, "R1 rd", int'(rd), 0);
    chk(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
    chk(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
  endtask

  task automatic t_stop_idle();
    clr();
    cmd(2'd3, 3'd0);
    step(60);
    chk(n_fall == 0, "R7 stop while idle", n_fall, 0);
  endtask

  task automatic t_single();
    logic [6:0] s0;
    clr();
    resp_ready = 1'b1;
    s0 = seq;
    cmd(2'd1, 3'd5);
    step(80);
    chk(n_fall == 1, "R4 single conversion count", n_fall, 1);
    chk(n_got == 4, "R3 entries per conversion", n_got, 4);
    chk_group(0, 3'd5, s0 + 7'd1, "R3 entry order/format");
    chk(last_low == 2, "R2 start width", last_low, 2);
    chk(last_rd == 2, "R2 read width", last_rd, 2);
  endtask

  task automatic t_scan();
    logic [6:0] s0;
    clr();
    resp_ready = 1'b1;
    s0 = seq;
    cmd(2'd2, 3'd6);
    step(4);
    cmd(2'd1, 3'd2);  // ignored while scanning
    wait_falls(4);
    cmd(2'd3, 3'd0);
    step(150);
    chk(n_fall == 4, "R7 stop keeps in-flight only", n_fall, 4);
    chk(n_got == 16, "R7 in-flight conversion stored", n_got, 16);
    for (int g = 0; g < 4; g++)
      chk_group(g, 3'(6 + g), s0 + 7'(g + 1), "R5 R8 channel sequence");
    for (int k = 1; k < 4; k++)
      chk(fall_t[k] - fall_t[k-1] == GAP, "R6 start spacing", fall_t[k] - fall_t[k-1], GAP);
  endtask

  task automatic t_priority();
    clr();
    resp_ready = 1'b0;
    cmd(2'd1, 3'd1);
    step(3);
    oth_valid = 1'b1; oth_data = 32'hA5A5_0001;
    @(negedge clk);
    chk(resp_valid && !resp_src, "R10 other granted", int'(resp_src), 0);
    chk(resp_data == 32'hA5A5_0001, "R11 other data forwarded", int'(resp_data), 32'hA5A5_0001);
    chk(oth_ready == 1'b0, "R11 ready follows downstream", int'(oth_ready), 0);
    step(1);
    resp_ready = 1'b1;
    @(negedge clk);
    chk(oth_ready == 1'b1, "R11 ready follows downstream", int'(oth_ready), 1);
    step(80);
    chk(n_fall == 1, "R11 conversion ran in background", n_fall, 1);
    chk(n_got == 0, "R10 queue held while other pending", n_got, 0);
    @(negedge clk);
    chk(!resp_src, "R10 other still first", int'(resp_src), 0);
    step(1);
    oth_valid = 1'b0;
    step(10);
    chk(n_got == 4, "R10 queue drains when other idle", n_got, 4);
  endtask

  task automatic t_defer();
    logic [6:0] s0;
    int nf;
    clr();
    resp_ready = 1'b0;
    s0 = seq;
    cmd(2'd2, 3'd0);
    step(250);
    chk(n_fall == 2, "R9 start held when queue short", n_fall, 2);
    chk(ovf == 1'b1, "R9 flag set", int'(ovf), 1);
    chk(n_got == 0, "R9 nothing delivered while stalled", n_got, 0);
    resp_ready = 1'b1;
    wait_falls(4);
    cmd(2'd3, 3'd0);
    step(150);
    nf = n_fall;
    chk(n_got == 4 * nf, "R9 whole sample sets only", n_got, 4 * nf);
    for (int g = 0; g < nf && g < 16; g++)
      chk_group(g, 3'(g), s0 + 7'(g + 1), "R9 R5 order after stall");
    chk(ovf == 1'b1, "R9 flag sticky", int'(ovf), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_stop_idle();
    t_single();
    t_scan();
    t_priority();
    t_defer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule